// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Access Master

This block lets the core of a field-bus slave read or write one byte of the external serial EEPROM that holds the slave's address and configuration. The core puts a byte address on `req_addr`, a data byte on `req_wdata` for a write, and the direction on `req_write`. It then pulses `req_valid` while the block is idle. The block runs the whole two-wire transaction on open-drain SCL and SDA lines. It checks the acknowledge after every byte it sends. When the transaction has ended it reports the result through a one-cycle `done` pulse with `err` and `rdata`.

The device select is fixed. The select byte always carries the family code 1010, then the three chip-select bits 000, then the direction bit. A read begins with the same write-addressing phase that a write uses, so the byte pointer inside the EEPROM is set first. A repeated START follows, then the select byte with the read bit, and one data byte comes back. The master answers that byte with no acknowledge and then closes with STOP. The block drives the bus only by pulling lines low: `scl_pull` and `sda_pull` at 1 mean the line is pulled low, and at 0 the line is released. `sda_in` is the resolved level of the SDA wire.

Every bit lasts four quarter periods, and each quarter is `QUARTER_CYCLES` system clocks. The controller has eight states:
- IDLE: waiting for a request.
- START: the START condition.
- SEND: shifting out a byte, MSB first.
- ACK: SDA released, the acknowledge is sampled.
- RSTART: the repeated START.
- RECV: shifting in the read byte.
- MNACK: the master's no-acknowledge.
- STOP: the STOP condition.

The transitions are:
- IDLE→START when a request is accepted.
- START→SEND with the write select byte.
- SEND→ACK after eight bits.
- ACK→SEND with the byte address, after the select byte is acknowledged.
- ACK→SEND with the data byte, after the address is acknowledged in a write.
- ACK→RSTART after the address is acknowledged in a read.
- RSTART→SEND with the read select byte.
- ACK→RECV after the read select byte is acknowledged.
- RECV→MNACK after eight bits.
- MNACK→STOP.
- ACK→STOP after the data byte is acknowledged, or after any missing acknowledge.
- STOP→IDLE, which pulses `done`.

Top module: `ee_byte_master`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `scl_pull` and `sda_pull` are 0. Both pulls stay 0 whenever `busy` is 0.
- R2: A `req_valid` seen while `busy` is 0 is accepted, and `busy` is 1 from the next cycle. A `req_valid` seen while `busy` is 1 is ignored: it starts no further transaction and writes no byte.
- R3: Every transaction starts with SDA falling while SCL is high. The first byte sent is 0xA0, which is the family code 1010 in bits 7..4, select bits 000 in bits 3..1, and 0 (write) in bit 0.
- R4: A write sends START, 0xA0, the byte address and the data byte, each followed by an acknowledge slot, and then STOP. It uses exactly one START, and the EEPROM then holds the data byte at that address.
- R5: A read sends START, 0xA0 and the byte address with their acknowledge slots. It then sends a repeated START and 0xA1 (bit 0 = 1, read), takes one data byte, and sends STOP. It uses exactly two STARTs, and `rdata` equals the stored byte.
- R6: Bytes are sent MSB first. SDA changes only while SCL is low, except in the START, repeated START and STOP conditions.
- R7: During acknowledge slots and read data bits the master releases SDA. On the ninth clock after the read byte the master leaves SDA high (no acknowledge).
- R8: If any acknowledge slot finds SDA high, the master sends no further byte and ends with STOP, and `err` is 1 at `done`. In a refused write no data is stored.
- R9: `done` is a single-cycle pulse in the cycle in which `busy` falls. `err` and `rdata` are valid from that cycle until the next accepted request. `rdata` changes only at the end of a successful read, and `err` rises only together with `done`.
- R10: The SCL period is 4×`QUARTER_CYCLES` system clocks, and SCL is high for 2×`QUARTER_CYCLES` clocks of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 8 | EEPROM byte address |
| req_wdata | input | 8 | Data byte for a write |
| sda_in | input | 1 | Level sensed on the SDA wire |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Missing acknowledge in the last transaction |
| rdata | output | 8 | Byte returned by the last successful read |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The embedded properties check several rules on every cycle:
- SDA holds still while SCL stays high outside the START, repeated START and STOP states.
- Both lines are released while idle and SDA is released whenever the slave is expected to talk.
- `done` is a lone pulse coinciding with the fall of `busy`, and an error flag never appears without it.
- The quarter ticks never come back to back.

Only the bench's EEPROM model can show that the bytes arrive in the right order and with the right values, that the repeated START and the no-acknowledge are really there, that a refused byte stops the transfer at the right slot, and that the measured SCL period and high time follow the divider.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int EE_BYTE_W = 8;
    localparam logic [3:0] EE_FAMILY = 4'b1010;
    localparam logic [2:0] EE_SELECT = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_ACK,
        ST_RSTART,
        ST_RECV,
        ST_MNACK,
        ST_STOP
    } ee_state_t;

    typedef enum logic [1:0] {
        PH_DEVW,
        PH_ADDR,
        PH_DATA,
        PH_DEVR
    } ee_phase_t;

    function automatic logic [EE_BYTE_W-1:0] ee_dev_byte(input logic rd);
        return {EE_FAMILY, EE_SELECT, rd};
    endfunction

endpackage

// File: rtl/ee_quarter_timer.sv
module ee_quarter_timer #(
    parameter int QUARTER_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (QUARTER_CYCLES > 1) begin : g_gap
            // R10: quarters are spaced by the divider, never one cycle apart
            a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ee_shift_byte.sv
module ee_shift_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (shift) begin
            value <= {value[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/ee_byte_master.sv
module ee_byte_master
    import ee_pkg::*;
#(
    parameter int QUARTER_CYCLES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [EE_BYTE_W-1:0] req_addr,
    input  logic [EE_BYTE_W-1:0] req_wdata,
    input  logic                 sda_in,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [EE_BYTE_W-1:0] rdata,
    output logic                 scl_pull,
    output logic                 sda_pull
);
    localparam int BCW = $clog2(EE_BYTE_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(EE_BYTE_W - 1);

    ee_state_t state;
    ee_phase_t phase;
    logic [1:0] q;
    logic [BCW-1:0] bitcnt;
    logic op_wr;
    logic [EE_BYTE_W-1:0] op_addr, op_data;
    logic ack_miss;
    logic tick, bit_end, sample;

    logic sh_load, sh_shift, sh_in;
    logic [EE_BYTE_W-1:0] sh_val, shq;

    assign busy    = (state != ST_IDLE);
    assign bit_end = tick && (q == 2'd3);
    assign sample  = tick && (q == 2'd1);

    ee_quarter_timer #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    ee_shift_byte #(.W(EE_BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .shift(sh_shift), .bit_in(sh_in), .value(shq)
    );

    // shifter control
    always_comb begin
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_in    = 1'b0;
        sh_val   = '0;
        unique case (state)
            ST_IDLE: begin
                sh_load = req_valid;
                sh_val  = ee_dev_byte(1'b0);
            end
            ST_SEND: sh_shift = bit_end && (bitcnt != LAST_BIT);
            ST_ACK: begin
                if (bit_end && !ack_miss) begin
                    if (phase == PH_DEVW) begin
                        sh_load = 1'b1;
                        sh_val  = op_addr;
                    end else if (phase == PH_ADDR && op_wr) begin
                        sh_load = 1'b1;
                        sh_val  = op_data;
                    end
                end
            end
            ST_RSTART: begin
                sh_load = bit_end;
                sh_val  = ee_dev_byte(1'b1);
            end
            ST_RECV: begin
                sh_shift = sample;
                sh_in    = sda_in;
            end
            ST_MNACK, ST_STOP, ST_START: ;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEVW;
            q        <= 2'd0;
            bitcnt   <= '0;
            op_wr    <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
            ack_miss <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) q <= q + 2'd1;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_START;
                        phase    <= PH_DEVW;
                        q        <= 2'd0;
                        bitcnt   <= '0;
                        op_wr    <= req_write;
                        op_addr  <= req_addr;
                        op_data  <= req_wdata;
                        ack_miss <= 1'b0;
                        err      <= 1'b0;
                    end
                end
                ST_START: if (bit_end) state <= ST_SEND;
                ST_SEND: begin
                    if (bit_end) begin
                        if (bitcnt == LAST_BIT) begin
                            state  <= ST_ACK;
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (sample) ack_miss <= sda_in;
                    if (bit_end) begin
                        if (ack_miss) begin
                            state <= ST_STOP;
                        end else begin
                            unique case (phase)
                                PH_DEVW: begin
                                    phase <= PH_ADDR;
                                    state <= ST_SEND;
                                end
                                PH_ADDR: begin
                                    if (op_wr) begin
                                        phase <= PH_DATA;
                                        state <= ST_SEND;
                                    end else begin
                                        state <= ST_RSTART;
                                    end
                                end
                                PH_DATA: state <= ST_STOP;
                                PH_DEVR: state <= ST_RECV;
                            endcase
                        end
                    end
                end
                ST_RSTART: begin
                    if (bit_end) begin
                        phase <= PH_DEVR;
                        state <= ST_SEND;
                    end
                end
                ST_RECV: begin
                    if (bit_end) begin
                        if (bitcnt == LAST_BIT) begin
                            state  <= ST_MNACK;
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MNACK: if (bit_end) state <= ST_STOP;
                ST_STOP: begin
                    if (bit_end) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        err   <= ack_miss;
                        if (!op_wr && !ack_miss) rdata <= shq;
                    end
                end
            endcase
        end
    end

    // line drive per state and quarter
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_START, ST_RSTART: begin
                scl_pull = (q == 2'd0) || (q == 2'd3);
                sda_pull = (q >= 2'd2);
            end
            ST_SEND: begin
                scl_pull = (q == 2'd0) || (q == 2'd3);
                sda_pull = ~shq[EE_BYTE_W-1];
            end
            ST_ACK, ST_RECV, ST_MNACK: begin
                scl_pull = (q == 2'd0) || (q == 2'd3);
            end
            ST_STOP: begin
                scl_pull = (q == 2'd0);
                sda_pull = (q <= 2'd1);
            end
        endcase
    end

    logic edge_state;
    assign edge_state = (state == ST_START) || (state == ST_RSTART) || (state == ST_STOP);

    // R1: idle bus is fully released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull));

    // R2: an idle request is taken at once
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R6: data line still while clock high outside bus conditions
    a_r6_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && $past(!scl_pull) && !edge_state && !$past(edge_state))
        |-> $stable(sda_pull));

    // R7: master listens during acknowledge, read bits and its no-acknowledge
    a_r7_listen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK || state == ST_RECV || state == ST_MNACK) |-> !sda_pull);

    // R9: done is a single pulse and coincides with idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: the error flag appears only with done
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

endmodule

// File: tb/tb_ee_byte_master.sv
module tb_ee_byte_master;
    localparam int Q = 5;
    localparam int TCLK = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic busy, done, err, scl_pull, sda_pull;
    logic [7:0] rdata;
    logic slv_low = 1'b0;

    wire scl = ~scl_pull;
    wire sda = ~(sda_pull | slv_low);

    always #4 clk = ~clk;

    ee_byte_master #(.QUARTER_CYCLES(Q)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sda_in(sda),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    int n_tests = 0, n_fail = 0;

    // EEPROM model and bench expectation
    logic [7:0] smem [256];
    logic [7:0] emem [256];
    int sl_ph = -1, sl_bitn = 0, sl_slot = 0, nack_slot = 0;
    logic [7:0] sl_sh = '0, sl_out = '0, sl_ptr = '0;
    int starts = 0, stops = 0, log_n = 0;
    logic [7:0] log_b [8];
    logic mack_bit = 1'b0;

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] sel_byte(input bit rd);
        return {4'b1010, 3'b000, rd};
    endfunction

    always @(negedge sda) begin
        if (scl === 1'b1) begin
            starts++;
            sl_ph = 0;
            sl_bitn = 0;
            slv_low = 1'b0;
        end
    end

    always @(posedge sda) begin
        if (scl === 1'b1) begin
            stops++;
            sl_ph = -1;
            slv_low = 1'b0;
        end
    end

    always @(posedge scl) begin
        if (sl_ph >= 0) begin
            if (sl_bitn < 8) sl_sh = {sl_sh[6:0], sda};
            if (sl_bitn == 8 && sl_ph == 5) mack_bit = sda;
            sl_bitn++;
        end
    end

    always @(negedge scl) begin
        if (sl_ph >= 0) begin
            if (sl_bitn == 8) begin
                if (sl_ph == 5) begin
                    slv_low = 1'b0;
                end else begin
                    bit ack;
                    int nxt;
                    sl_slot++;
                    if (log_n < 8) log_b[log_n] = sl_sh;
                    log_n++;
                    ack = (sl_slot != nack_slot);
                    nxt = -1;
                    case (sl_ph)
                        0: begin
                            if (sl_sh[7:1] != 7'h50) ack = 1'b0;
                            nxt = sl_sh[0] ? 3 : 1;
                        end
                        1: begin
                            if (ack) sl_ptr = sl_sh;
                            nxt = 2;
                        end
                        2: begin
                            if (ack) smem[sl_ptr] = sl_sh;
                            nxt = 4;
                        end
                        default: ack = 1'b0;
                    endcase
                    if (ack) begin
                        slv_low = 1'b1;
                        sl_ph = nxt;
                    end else begin
                        slv_low = 1'b0;
                        sl_ph = -1;
                    end
                end
            end else if (sl_bitn == 9) begin
                slv_low = 1'b0;
                sl_bitn = 0;
                if (sl_ph == 3) begin
                    sl_ph = 5;
                    sl_out = smem[sl_ptr];
                    slv_low = ~sl_out[7];
                end else if (sl_ph == 5) begin
                    sl_ph = -1;
                end
            end else if (sl_bitn >= 1 && sl_bitn <= 7 && sl_ph == 5) begin
                slv_low = ~sl_out[7 - sl_bitn];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [7:0] a, input logic [7:0] d, input int nslot);
        sl_slot = 0;
        log_n = 0;
        nack_slot = nslot;
        mack_bit = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", busy, 1);
        while (!done) @(negedge clk);
    endtask

    task automatic op_check(input bit wr, input logic [7:0] a, input logic [7:0] d, input int nslot);
        logic [7:0] prev_rd;
        int s0, p0;
        bit exp_err;
        prev_rd = rdata;
        s0 = starts;
        p0 = stops;
        run_op(wr, a, d, nslot);
        exp_err = (nslot != 0);
        chk("R8 err flag", err, exp_err);
        chk("R9 busy low at done", busy, 0);
        chk("R8 stop count", stops - p0, 1);
        if (!exp_err) begin
            chk("R3 first byte", log_b[0], sel_byte(1'b0));
            chk("R4 address byte", log_b[1], a);
            chk("R4 byte count", log_n, 3);
            if (wr) begin
                chk("R4 data byte", log_b[2], d);
                chk("R4 one start", starts - s0, 1);
                chk("R4 stored", smem[a], d);
                emem[a] = d;
            end else begin
                chk("R5 read select", log_b[2], sel_byte(1'b1));
                chk("R5 two starts", starts - s0, 2);
                chk("R5 rdata", rdata, emem[a]);
                chk("R7 master no-ack", mack_bit, 1);
            end
        end else begin
            chk("R8 bytes until refusal", log_n, nslot);
            chk("R8 memory untouched", smem[a], emem[a]);
            chk("R9 rdata kept", rdata, prev_rd);
        end
        @(negedge clk);
        chk("R9 done single pulse", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = init_byte(i);
            emem[i] = init_byte(i);
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", busy, 0);
        chk("R1 done at reset", done, 0);
        chk("R1 scl released", scl_pull, 0);
        chk("R1 sda released", sda_pull, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        starts = 0;
        stops = 0;

        // directed write and read
        op_check(1'b1, 8'h00, 8'h5A, 0);
        op_check(1'b0, 8'h00, 8'h00, 0);
        op_check(1'b1, 8'hFF, 8'h81, 0);
        op_check(1'b0, 8'hFF, 8'h00, 0);
        op_check(1'b0, 8'h7E, 8'h00, 0);

        // R10 SCL period and high time
        begin
            time t1, t2, t3;
            fork
                op_check(1'b1, 8'h11, 8'hC3, 0);
                begin
                    @(posedge scl) t1 = $time;
                    @(posedge scl) t2 = $time;
                    @(negedge scl) t3 = $time;
                    chk("R10 scl period", int'(t2 - t1), 4 * Q * TCLK);
                    chk("R10 scl high time", int'(t3 - t2), 2 * Q * TCLK);
                end
            join
        end

        // R2 request during busy is ignored
        begin
            int s0;
            s0 = starts;
            fork
                op_check(1'b1, 8'h22, 8'h99, 0);
                begin
                    repeat (60) @(negedge clk);
                    req_valid = 1'b1;
                    req_write = 1'b1;
                    req_addr = 8'h33;
                    req_wdata = 8'h44;
                    @(negedge clk);
                    req_valid = 1'b0;
                end
            join
            chk("R2 single transaction", starts - s0, 1);
            chk("R2 ignored address unwritten", smem[8'h33], emem[8'h33]);
            repeat (4 * Q) @(negedge clk);
            chk("R2 stays idle", busy, 0);
        end

        // R8 refusal at every acknowledge slot
        for (int s = 1; s <= 3; s++) begin
            op_check(1'b1, 8'h40 + 8'(s), 8'hE0, s);
            op_check(1'b0, 8'h50 + 8'(s), 8'h00, s);
        end

        // random mix
        for (int k = 0; k < 30; k++) begin
            bit wr;
            logic [7:0] a, d;
            int ns;
            wr = 1'($urandom % 2);
            a = 8'($urandom);
            d = 8'($urandom);
            ns = (($urandom % 5) == 0) ? int'(1 + ($urandom % 3)) : 0;
            op_check(wr, a, d, ns);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule